// File: doc/BRIEF.md
# Synapse Array Configuration Store

This block keeps the per-synapse settings for a square array of plastic synapses, 128 rows by 128 columns at the default size. A configuration port carries a row address, a column address, three data bits and an active-low write strobe. One strobe event at the selected synapse does three things. It records where the synapse takes its input from, either the local recurrent neuron or an incoming address event. It records whether the synapse is excitatory or inhibitory. It also forces the synapse's binary efficacy to a chosen starting value.

The efficacy bit is also written by the learning logic through its own update port. When both writers target the same synapse in the same cycle, the configuration write wins. The same configuration address can be used only to observe a synapse: its efficacy comes back on a single registered bit, built as a wired-OR of row and column selects. Reading never alters any stored state, so the array can be scanned while spikes keep flowing. The full source-select and polarity maps are exported flat so the spike path can use them.

Top module: `syn_array_cfg`

## Requirements
- R1: After reset every synapse is recurrent (source bit 0), excitatory (polarity bit 0) and depressed (efficacy 0), and `rd_bit_o` is 0.
- R2: Each address is decoded into one-hot row and column selects. A write touches only the synapse at (row, col), and only while `cfg_en_i` is 1. A strobe edge with `cfg_en_i` at 0 changes nothing.
- R3: A write stores `cfg_src_i` into `src_map_o` bit row*COLS+col, where 1 means address-event input and 0 means recurrent input.
- R4: The same write stores `cfg_inh_i` into `inh_map_o` bit row*COLS+col, where 1 means inhibitory and 0 means excitatory.
- R5: The same write sets the selected efficacy to `cfg_init_i`, where 1 means potentiated and 0 means depressed.
- R6: `cfg_wr_ni` is sampled on the clock. A write happens only on the edge where it is first seen low after being high, so exactly one write occurs for each falling transition. Changes to the data bits while it stays low have no effect.
- R7: `rd_bit_o` is registered. One clock after `cfg_en_i` and the address are applied, it shows the efficacy of that synapse as it was before that edge. It is 0 in the cycle after `cfg_en_i` is 0.
- R8: When `lrn_en_i` is 1, the efficacy at (`lrn_row_i`, `lrn_col_i`) takes `lrn_val_i` on that edge. The source and polarity maps are unaffected.
- R9: When a write and a learning update hit the same synapse on the same edge, the efficacy takes `cfg_init_i`. When they hit different synapses, both take effect.
- R10: Reading (`cfg_en_i` at 1 with no strobe edge) leaves every stored bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Enables the configuration row and column decoders |
| cfg_row_i | input | ROW_AW (7) | Configuration and readback row address |
| cfg_col_i | input | COL_AW (7) | Configuration and readback column address |
| cfg_src_i | input | 1 | Source-select value to store |
| cfg_inh_i | input | 1 | Polarity value to store |
| cfg_init_i | input | 1 | Initial efficacy forced by a write |
| cfg_wr_ni | input | 1 | Write strobe, active low, acts on its falling transition |
| lrn_en_i | input | 1 | Learning update valid |
| lrn_row_i | input | ROW_AW (7) | Learning update row |
| lrn_col_i | input | COL_AW (7) | Learning update column |
| lrn_val_i | input | 1 | New efficacy from the learning logic |
| rd_bit_o | output | 1 | Registered efficacy of the addressed synapse |
| src_map_o | output | ROWS*COLS (16384) | Source-select bit per synapse, index row*COLS+col |
| inh_map_o | output | ROWS*COLS (16384) | Polarity bit per synapse, index row*COLS+col |

## Verification
The configuration write's efficacy initialise and a learning update can land on the same edge. The bench provokes this in three ways: a strobe edge and an update aimed at one synapse with opposite values, the same case with the values swapped, and a pair aimed at neighbouring columns of one row. Each case is judged by a readback in the next cycle against a reference model that applies the learning update first and the initialise second. A strobe held low across changing data bits and a strobe edge with the decoders disabled are also compared every clock against the model's maps.

// File: rtl/syn_cfg_pkg.sv
package syn_cfg_pkg;
  typedef enum logic {SRC_RECURRENT = 1'b0, SRC_EVENT = 1'b1} src_e;
  typedef enum logic {POL_EXC = 1'b0, POL_INH = 1'b1} pol_e;
  typedef enum logic {EFF_DEPRESSED = 1'b0, EFF_POTENTIATED = 1'b1} eff_e;
  localparam int unsigned CFG_PLANES = 2;  // 0: source select, 1: polarity
endpackage

// File: rtl/syn_addr_dec.sv
module syn_addr_dec #(
  parameter int unsigned AW = 7,
  localparam int unsigned N = 1 << AW
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot_o[i] = en_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/syn_wr_strobe.sv
module syn_wr_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  output logic fire_o
);
  logic wr_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_n_q <= 1'b1;
    else         wr_n_q <= wr_ni;
  end

  // fires on the first sampled low after a high
  assign fire_o = wr_n_q & ~wr_ni;
endmodule

// File: rtl/syn_cfg_plane.sv
module syn_cfg_plane #(
  parameter int unsigned ROWS = 128,
  parameter int unsigned COLS = 128,
  localparam int unsigned N = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ROWS-1:0] row_hot_i,
  input  logic [COLS-1:0] col_hot_i,
  input  logic            we_i,
  input  logic            val_i,
  output logic [N-1:0]    map_o
);
  logic [COLS-1:0] q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[r] <= '0;
      else if (we_i && row_hot_i[r])
        q[r] <= (q[r] & ~col_hot_i) | (col_hot_i & {COLS{val_i}});
    end
    assign map_o[r*COLS +: COLS] = q[r];
  end
endmodule

// File: rtl/syn_eff_plane.sv
module syn_eff_plane #(
  parameter int unsigned ROWS = 128,
  parameter int unsigned COLS = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  // initialise port, wins on collision
  input  logic [ROWS-1:0] ini_row_hot_i,
  input  logic [COLS-1:0] ini_col_hot_i,
  input  logic            ini_we_i,
  input  logic            ini_val_i,
  // learning port
  input  logic [ROWS-1:0] lrn_row_hot_i,
  input  logic [COLS-1:0] lrn_col_hot_i,
  input  logic            lrn_val_i,
  // wired-OR readback
  input  logic [ROWS-1:0] rd_row_hot_i,
  input  logic [COLS-1:0] rd_col_hot_i,
  output logic            rd_bit_o
);
  logic [COLS-1:0] eff_q    [ROWS];
  logic [COLS-1:0] eff_next [ROWS];
  logic [ROWS-1:0] row_hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] lrn_mask, ini_mask, after_lrn;
    logic            row_we;

    assign lrn_mask  = lrn_row_hot_i[r] ? lrn_col_hot_i : '0;
    assign ini_mask  = (ini_we_i && ini_row_hot_i[r]) ? ini_col_hot_i : '0;
    assign after_lrn = (eff_q[r] & ~lrn_mask) | (lrn_mask & {COLS{lrn_val_i}});
    assign eff_next[r] = (after_lrn & ~ini_mask) | (ini_mask & {COLS{ini_val_i}});
    assign row_we = (|lrn_mask) | (|ini_mask);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     eff_q[r] <= '0;
      else if (row_we) eff_q[r] <= eff_next[r];
    end

    assign row_hit[r] = rd_row_hot_i[r] & (|(eff_q[r] & rd_col_hot_i));
  end

  assign rd_bit_o = |row_hit;
endmodule

// File: rtl/syn_array_cfg.sv
module syn_array_cfg #(
  parameter int unsigned ROW_AW = 7,
  parameter int unsigned COL_AW = 7,
  localparam int unsigned ROWS = 1 << ROW_AW,
  localparam int unsigned COLS = 1 << COL_AW,
  localparam int unsigned N    = ROWS * COLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic [ROW_AW-1:0] cfg_row_i,
  input  logic [COL_AW-1:0] cfg_col_i,
  input  logic              cfg_src_i,
  input  logic              cfg_inh_i,
  input  logic              cfg_init_i,
  input  logic              cfg_wr_ni,
  input  logic              lrn_en_i,
  input  logic [ROW_AW-1:0] lrn_row_i,
  input  logic [COL_AW-1:0] lrn_col_i,
  input  logic              lrn_val_i,
  output logic              rd_bit_o,
  output logic [N-1:0]      src_map_o,
  output logic [N-1:0]      inh_map_o
);
  import syn_cfg_pkg::*;

  logic [ROWS-1:0] cfg_row_hot, lrn_row_hot;
  logic [COLS-1:0] cfg_col_hot, lrn_col_hot;
  logic            wr_fire;
  logic            rd_raw, rd_q;
  logic [CFG_PLANES-1:0]        plane_val;
  logic [CFG_PLANES-1:0][N-1:0] plane_map;

  syn_addr_dec #(.AW(ROW_AW)) u_cfg_row (.en_i(cfg_en_i), .addr_i(cfg_row_i), .hot_o(cfg_row_hot));
  syn_addr_dec #(.AW(COL_AW)) u_cfg_col (.en_i(cfg_en_i), .addr_i(cfg_col_i), .hot_o(cfg_col_hot));
  syn_addr_dec #(.AW(ROW_AW)) u_lrn_row (.en_i(lrn_en_i), .addr_i(lrn_row_i), .hot_o(lrn_row_hot));
  syn_addr_dec #(.AW(COL_AW)) u_lrn_col (.en_i(lrn_en_i), .addr_i(lrn_col_i), .hot_o(lrn_col_hot));

  syn_wr_strobe u_strobe (.clk_i(clk_i), .rst_ni(rst_ni), .wr_ni(cfg_wr_ni), .fire_o(wr_fire));

  assign plane_val = {cfg_inh_i, cfg_src_i};

  for (genvar p = 0; p < CFG_PLANES; p++) begin : g_plane
    syn_cfg_plane #(.ROWS(ROWS), .COLS(COLS)) u_plane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .row_hot_i(cfg_row_hot),
      .col_hot_i(cfg_col_hot),
      .we_i     (wr_fire),
      .val_i    (plane_val[p]),
      .map_o    (plane_map[p])
    );
  end

  assign src_map_o = plane_map[0];
  assign inh_map_o = plane_map[1];

  syn_eff_plane #(.ROWS(ROWS), .COLS(COLS)) u_eff (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ini_row_hot_i(cfg_row_hot),
    .ini_col_hot_i(cfg_col_hot),
    .ini_we_i     (wr_fire),
    .ini_val_i    (cfg_init_i),
    .lrn_row_hot_i(lrn_row_hot),
    .lrn_col_hot_i(lrn_col_hot),
    .lrn_val_i    (lrn_val_i),
    .rd_row_hot_i (cfg_row_hot),
    .rd_col_hot_i (cfg_col_hot),
    .rd_bit_o     (rd_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= EFF_DEPRESSED;
    else         rd_q <= rd_raw;
  end

  assign rd_bit_o = rd_q;
endmodule

// File: rtl/syn_array_cfg_chk.sv
module syn_array_cfg_chk #(
  parameter int unsigned ROW_AW = 7,
  parameter int unsigned COL_AW = 7,
  localparam int unsigned COLS = 1 << COL_AW,
  localparam int unsigned N    = (1 << ROW_AW) * COLS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_en_i,
  input logic [ROW_AW-1:0] cfg_row_i,
  input logic [COL_AW-1:0] cfg_col_i,
  input logic              cfg_src_i,
  input logic              cfg_inh_i,
  input logic              cfg_wr_ni,
  input logic              rd_bit_o,
  input logic [N-1:0]      src_map_o,
  input logic [N-1:0]      inh_map_o
);
  logic        wr_n_seen;
  logic        edge_wr;
  int unsigned sel_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_n_seen <= 1'b1;
    else         wr_n_seen <= cfg_wr_ni;
  end

  assign edge_wr = cfg_en_i && wr_n_seen && !cfg_wr_ni;
  assign sel_idx = int'(cfg_row_i) * COLS + int'(cfg_col_i);

  assert_src_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_wr |=> src_map_o[$past(sel_idx)] == $past(cfg_src_i));

  assert_pol_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_wr |=> inh_map_o[$past(sel_idx)] == $past(cfg_inh_i));

  // R2, R6, R8, R10: config maps move only on an enabled strobe edge
  assert_maps_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_wr |=> ($stable(src_map_o) && $stable(inh_map_o)));

  assert_rd_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> !rd_bit_o);
endmodule

bind syn_array_cfg syn_array_cfg_chk #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_chk (.*);

// File: tb/syn_array_cfg_tb_top.sv
module syn_array_cfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 7;
  localparam int COLS = 1 << AW;
  localparam int N    = COLS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, src = 0, inh = 0, init = 0, wr_n = 1;
  logic [AW-1:0] row = '0, col = '0, lrow = '0, lcol = '0;
  logic len = 0, lval = 0;
  logic rd_bit;
  logic [N-1:0] src_map, inh_map;

  int checks = 0, errors = 0;
  bit done = 0;
  bit running = 0;
  string cur_tag = "R1";

  // reference model
  logic [N-1:0] m_src, m_inh, m_eff;
  logic m_prev, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  syn_array_cfg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_row_i(row), .cfg_col_i(col),
    .cfg_src_i(src), .cfg_inh_i(inh), .cfg_init_i(init), .cfg_wr_ni(wr_n),
    .lrn_en_i(len), .lrn_row_i(lrow), .lrn_col_i(lcol), .lrn_val_i(lval),
    .rd_bit_o(rd_bit), .src_map_o(src_map), .inh_map_o(inh_map)
  );

  always @(posedge clk or negedge rst_n) begin
    int i, li;
    if (!rst_n) begin
      m_src = '0; m_inh = '0; m_eff = '0; m_prev = 1'b1; m_rd = 1'b0;
    end else begin
      i  = int'(row) * COLS + int'(col);
      li = int'(lrow) * COLS + int'(lcol);
      m_rd = en ? m_eff[i] : 1'b0;
      if (len) m_eff[li] = lval;
      if (en && m_prev && !wr_n) begin
        m_src[i] = src; m_inh[i] = inh; m_eff[i] = init;
      end
      m_prev = wr_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk(rd_bit === m_rd, {cur_tag, " rd_bit_o"}, 32'(rd_bit), 32'(m_rd));
      chk(src_map === m_src && inh_map === m_inh, {cur_tag, " maps (ones src/inh)"},
          ($countones(src_map) << 16) | $countones(inh_map),
          ($countones(m_src) << 16) | $countones(m_inh));
    end
  end

  function automatic int ix(input int r, input int c);
    return r * COLS + c;
  endfunction

  task automatic idle();
    en = 0; wr_n = 1; len = 0;
    @(negedge clk);
  endtask

  task automatic cfg_write(input int r, input int c, input bit s, input bit ih, input bit it);
    en = 1; row = AW'(r); col = AW'(c); src = s; inh = ih; init = it; wr_n = 1; len = 0;
    @(negedge clk);
    wr_n = 0;
    @(negedge clk);
    wr_n = 1; en = 0;
    @(negedge clk);
  endtask

  task automatic read_chk(input int r, input int c, input bit exp, input string tag);
    en = 1; row = AW'(r); col = AW'(c); wr_n = 1; len = 0;
    @(negedge clk);
    chk(rd_bit === exp, tag, 32'(rd_bit), 32'(exp));
    en = 0;
  endtask

  task automatic learn(input int r, input int c, input bit v);
    en = 0; wr_n = 1; len = 1; lrow = AW'(r); lcol = AW'(c); lval = v;
    @(negedge clk);
    len = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] snap_src, snap_inh, snap_eff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;

    // R1: reset state
    chk(src_map == '0 && inh_map == '0, "R1 maps cleared", $countones(src_map) + $countones(inh_map), 0);
    chk(rd_bit === 1'b0, "R1 rd_bit_o", 32'(rd_bit), 0);
    read_chk(64, 64, 1'b0, "R1 efficacy depressed");

    // R3 R4 R5: single writes including corners
    cur_tag = "R3/R4/R5";
    cfg_write(5, 9, 1, 0, 1);
    chk(src_map[ix(5,9)] === 1'b1, "R3 src bit", 32'(src_map[ix(5,9)]), 1);
    chk(inh_map[ix(5,9)] === 1'b0, "R4 pol bit", 32'(inh_map[ix(5,9)]), 0);
    read_chk(5, 9, 1'b1, "R5 init potentiated");
    cfg_write(0, 0, 0, 1, 1);
    cfg_write(127, 127, 1, 1, 1);
    chk(inh_map[ix(0,0)] === 1'b1 && inh_map[ix(127,127)] === 1'b1, "R4 corner pol",
        {inh_map[ix(0,0)], inh_map[ix(127,127)]}, 3);
    read_chk(127, 127, 1'b1, "R5 corner high");
    read_chk(127, 126, 1'b0, "R2 neighbour untouched");
    cfg_write(5, 9, 0, 1, 0);
    read_chk(5, 9, 1'b0, "R5 init depressed");
    chk(src_map[ix(5,9)] === 1'b0 && inh_map[ix(5,9)] === 1'b1, "R3 rewrite",
        {src_map[ix(5,9)], inh_map[ix(5,9)]}, 1);

    // R2: strobe edge with decoders disabled
    cur_tag = "R2";
    en = 0; row = 7'd40; col = 7'd41; src = 1; inh = 1; init = 1; wr_n = 1;
    @(negedge clk);
    wr_n = 0;
    @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    chk(src_map[ix(40,41)] === 1'b0 && inh_map[ix(40,41)] === 1'b0, "R2 disabled write",
        {src_map[ix(40,41)], inh_map[ix(40,41)]}, 0);
    read_chk(40, 41, 1'b0, "R2 disabled init");

    // R6: strobe held low, data changes ignored
    cur_tag = "R6";
    en = 1; row = 7'd3; col = 7'd100; src = 1; inh = 0; init = 1; wr_n = 1;
    @(negedge clk);
    wr_n = 0;
    @(negedge clk);
    src = 0; inh = 1; init = 0;
    repeat (3) @(negedge clk);
    wr_n = 1; en = 0;
    @(negedge clk);
    chk(src_map[ix(3,100)] === 1'b1 && inh_map[ix(3,100)] === 1'b0, "R6 one write per edge",
        {src_map[ix(3,100)], inh_map[ix(3,100)]}, 2);
    read_chk(3, 100, 1'b1, "R6 init kept");

    // R7: idle returns zero, readback latency
    cur_tag = "R7";
    idle();
    chk(rd_bit === 1'b0, "R7 idle zero", 32'(rd_bit), 0);
    read_chk(3, 100, 1'b1, "R7 one-cycle read");

    // R8: learning updates
    cur_tag = "R8";
    learn(10, 20, 1);
    learn(127, 0, 1);
    learn(3, 100, 0);
    read_chk(10, 20, 1'b1, "R8 learn up");
    read_chk(127, 0, 1'b1, "R8 learn corner");
    read_chk(3, 100, 1'b0, "R8 learn down");
    chk(src_map[ix(10,20)] === 1'b0, "R8 config untouched", 32'(src_map[ix(10,20)]), 0);

    // R9: same-edge collisions
    cur_tag = "R9";
    en = 1; row = 7'd20; col = 7'd30; src = 0; inh = 0; init = 1; wr_n = 1; len = 0;
    @(negedge clk);
    wr_n = 0; len = 1; lrow = 7'd20; lcol = 7'd30; lval = 0;
    @(negedge clk);
    wr_n = 1; len = 0; en = 0;
    @(negedge clk);
    read_chk(20, 30, 1'b1, "R9 init beats learn low");
    learn(20, 30, 0);
    en = 1; row = 7'd20; col = 7'd30; init = 0; wr_n = 1;
    learn(11, 11, 0);
    en = 1; wr_n = 0; len = 1; lrow = 7'd20; lcol = 7'd30; lval = 1;
    @(negedge clk);
    wr_n = 1; len = 0; en = 0;
    @(negedge clk);
    read_chk(20, 30, 1'b0, "R9 init beats learn high");
    en = 1; row = 7'd21; col = 7'd3; init = 1; wr_n = 1;
    @(negedge clk);
    wr_n = 0; len = 1; lrow = 7'd21; lcol = 7'd4; lval = 1;
    @(negedge clk);
    wr_n = 1; len = 0; en = 0;
    @(negedge clk);
    read_chk(21, 3, 1'b1, "R9 both apply init");
    read_chk(21, 4, 1'b1, "R9 both apply learn");

    // R10: scan leaves state unchanged
    cur_tag = "R10";
    snap_src = src_map; snap_inh = inh_map; snap_eff = m_eff;
    for (int k = 0; k < 64; k++) begin
      en = 1; wr_n = 1; row = AW'(k * 2); col = AW'(127 - k);
      @(negedge clk);
    end
    en = 0;
    @(negedge clk);
    chk(src_map === snap_src && inh_map === snap_inh, "R10 maps after scan",
        $countones(src_map ^ snap_src) + $countones(inh_map ^ snap_inh), 0);
    read_chk(5, 9, snap_eff[ix(5,9)], "R10 efficacy after scan");

    idle();
    running = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule